// File: doc/BRIEF.md
# Mid-Access Wait-State Controller

This block times one external memory access and lengthens it when an external device asks for more time. A start pulse begins the access with a programmed length of D cycles. The block then drives a cycle index from 1 to D, which the strobe generator uses to decide when each strobe changes. The strobe generator's per-cycle strobe edges come back through the block and are passed on. A done pulse marks the last counted cycle of the access.

When wait handling is enabled and D is four or more, the synchronised wait input is looked at once, at the middle of the access. For an even D this is index D/2. For an odd D it is index (D+1)/2, the first edge past the true middle. A high sample freezes the access from the next cycle onward. While frozen, the index holds and strobe edges are blocked. The wait input is checked again every frozen cycle, and counting resumes in the cycle after it is seen low. Strobe edges in the sampling cycle itself are never blocked.

Top module: `wait_state_ctrl`

## Requirements
- R1: While idle, a high `start_i` begins an access: D is taken from `dur_i`, with a value of 0 treated as 1, and `wait_en_i` is latched with it. The next cycle shows index 1. While an access is in progress, `start_i` and `dur_i` have no effect.
- R2: In each cycle that is not stalled, the index advances by one, from 1 up to D. While idle, `busy_o` is 0 and `cyc_idx_o` is 0.
- R3: The sampling index S is D/2 when D is even and (D+1)/2 when D is odd. Sampling takes place only when the latched enable is 1 and D is at least 4.
- R4: If `wait_i` is high at the end of the cycle whose index is S, `stall_o` is 1 from the next cycle onward. During the stall, `cyc_idx_o` shows S+1 and holds that value.
- R5: While stalled, `wait_i` is sampled every cycle. The first low sample ends the stall in the following cycle. So N consecutive high samples, starting at the sampling point, add exactly N stalled cycles, and the access lasts D+N cycles.
- R6: `edges_o` equals `edges_i` in every cycle where `stall_o` is 0, including the sampling cycle. `edges_o` is all zeros while `stall_o` is 1.
- R7: When the latched enable is 0, or D is less than 4, `wait_i` is ignored: there is never a stall and the access lasts exactly D cycles.
- R8: The value of `wait_i` in any cycle other than the sampling cycle or a stalled cycle has no effect.
- R9: `done_o` is high for exactly one cycle, the cycle with index D and no stall. The block is idle in the next cycle.
- R10: During and right after reset, `busy_o`, `stall_o` and `done_o` are 0 and `cyc_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an access (taken only while idle) |
| dur_i | input | DUR_W | Access length D in cycles |
| wait_en_i | input | 1 | Enables mid-access wait sampling |
| wait_i | input | 1 | Synchronised wait request |
| edges_i | input | N_EDGE | Strobe edges scheduled by the strobe generator for the current cycle |
| busy_o | output | 1 | Access in progress |
| cyc_idx_o | output | DUR_W | Current cycle index (1..D), 0 when idle |
| stall_o | output | 1 | Access frozen; strobe transitions held back |
| edges_o | output | N_EDGE | Strobe edges after stall gating |
| done_o | output | 1 | Final counted cycle of the access |

## Verification
The bench runs every access length from 1 to 10, with sampling enabled and disabled, and with the wait input held high for 0 to 3 consecutive samples from the sampling point. The 0-versus-1 high-sample cases show whether the sample is taken at S or one cycle off. The cases with two and three high samples check that the freeze lasts exactly as long as the wait input stays high.

A second wait pattern holds the input high in every cycle except the sampling cycle; no stall must result. A third pattern keeps `start_i` high, with a different length on `dur_i`, for the whole access; the access must be unaffected. Together, the odd and even lengths around 4 separate the two midpoint rules and the minimum-length threshold.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  // Shortest access length that takes part in wait sampling
  localparam int unsigned MIN_SAMPLE_LEN = 4;

  // Index (counted from 1) at whose closing edge the wait input is sampled
  function automatic int unsigned sample_point(input int unsigned len);
    return (len + 1) / 2;
  endfunction

  function automatic logic sampling_on(input logic en, input int unsigned len);
    return en && (len >= MIN_SAMPLE_LEN);
  endfunction

  // Zero-length requests run as a single cycle
  function automatic int unsigned clamp_len(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction
endpackage

// File: rtl/wsc_counter.sv
module wsc_counter
  import wsc_pkg::*;
#(
  parameter int DUR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             wait_en_i,
  input  logic             stall_i,
  output logic             busy_o,
  output logic [DUR_W-1:0] idx_o,
  output logic [DUR_W-1:0] len_o,
  output logic             en_o,
  output logic             done_o
);
  logic             busy_q;
  logic [DUR_W-1:0] idx_q;
  logic [DUR_W-1:0] len_q;
  logic             en_q;
  logic             last_cyc;

  assign last_cyc = busy_q && !stall_i && (idx_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      en_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= DUR_W'(1);
        len_q  <= DUR_W'(clamp_len(32'(dur_i)));
        en_q   <= wait_en_i;
      end
    end else if (stall_i) begin
      idx_q <= idx_q;
    end else if (last_cyc) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      idx_q <= idx_q + DUR_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign len_o  = len_q;
  assign en_o   = en_q;
  assign done_o = last_cyc;

  // R5: a stalled cycle never moves the index
  p_hold_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(stall_i) && $past(busy_q)) |-> (idx_q == $past(idx_q)));
  // R2: the index stays within 1..D during an access
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q >= DUR_W'(1) && idx_q <= len_q));
  // R9: done is followed by idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);
endmodule

// File: rtl/wsc_sampler.sv
module wsc_sampler
  import wsc_pkg::*;
#(
  parameter int DUR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [DUR_W-1:0] idx_i,
  input  logic [DUR_W-1:0] len_i,
  input  logic             en_i,
  input  logic             wait_i,
  output logic             samp_pt_o,
  output logic             stall_o
);
  logic stall_q;
  logic stall_d;
  logic armed;

  assign armed     = sampling_on(en_i, 32'(len_i));
  assign samp_pt_o = busy_i && armed && !stall_q &&
                     (idx_i == DUR_W'(sample_point(32'(len_i))));

  always_comb begin
    stall_d = 1'b0;
    if (busy_i && (samp_pt_o || stall_q)) stall_d = wait_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall_d;
  end

  assign stall_o = stall_q;

  // R4: a stall can only begin right after the sampling point
  p_stall_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !$past(stall_q)) |-> $past(samp_pt_o));
  // R7: no stall when sampling is off
  p_no_stall_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> (armed && busy_i));
  // R5: a low sample during a stall ends it
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !wait_i) |=> !stall_q);
endmodule

// File: rtl/wsc_edge_gate.sv
module wsc_edge_gate #(
  parameter int N_EDGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic [N_EDGE-1:0] edges_i,
  output logic [N_EDGE-1:0] edges_o
);
  for (genvar g = 0; g < N_EDGE; g++) begin : g_lane
    assign edges_o[g] = edges_i[g] & ~stall_i;
  end

  // R6: nothing leaves while frozen, everything passes otherwise
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> (edges_o == '0));
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |-> (edges_o == edges_i));
endmodule

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl
  import wsc_pkg::*;
#(
  parameter int DUR_W  = 4,
  parameter int N_EDGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DUR_W-1:0]  dur_i,
  input  logic              wait_en_i,
  input  logic              wait_i,
  input  logic [N_EDGE-1:0] edges_i,
  output logic              busy_o,
  output logic [DUR_W-1:0]  cyc_idx_o,
  output logic              stall_o,
  output logic [N_EDGE-1:0] edges_o,
  output logic              done_o
);
  logic             busy_w;
  logic [DUR_W-1:0] idx_w;
  logic [DUR_W-1:0] len_w;
  logic             en_w;
  logic             stall_w;
  logic             samp_pt_w;
  logic             done_w;

  wsc_counter #(.DUR_W(DUR_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dur_i(dur_i),
    .wait_en_i(wait_en_i), .stall_i(stall_w), .busy_o(busy_w),
    .idx_o(idx_w), .len_o(len_w), .en_o(en_w), .done_o(done_w)
  );

  wsc_sampler #(.DUR_W(DUR_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_w), .idx_i(idx_w),
    .len_i(len_w), .en_i(en_w), .wait_i(wait_i),
    .samp_pt_o(samp_pt_w), .stall_o(stall_w)
  );

  wsc_edge_gate #(.N_EDGE(N_EDGE)) u_gate (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_w),
    .edges_i(edges_i), .edges_o(edges_o)
  );

  assign busy_o    = busy_w;
  assign cyc_idx_o = idx_w;
  assign stall_o   = stall_w;
  assign done_o    = done_w;

  // R10: idle outputs are quiet
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (cyc_idx_o == '0 && !stall_o && !done_o));
  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/tb_wait_state_ctrl.sv
module tb_wait_state_ctrl;
  localparam int DUR_W  = 4;
  localparam int N_EDGE = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [DUR_W-1:0]  dur_i = '0;
  logic              wait_en_i = 1'b0;
  logic              wait_i = 1'b0;
  logic [N_EDGE-1:0] edges_i = '0;
  logic              busy_o;
  logic [DUR_W-1:0]  cyc_idx_o;
  logic              stall_o;
  logic [N_EDGE-1:0] edges_o;
  logic              done_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wait_state_ctrl #(.DUR_W(DUR_W), .N_EDGE(N_EDGE)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dur_i(dur_i),
    .wait_en_i(wait_en_i), .wait_i(wait_i), .edges_i(edges_i),
    .busy_o(busy_o), .cyc_idx_o(cyc_idx_o), .stall_o(stall_o),
    .edges_o(edges_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Midpoint restated from the requirement text
  function automatic int mid_of(input int d);
    if (d % 2 == 0) return d / 2;
    return (d + 1) / 2;
  endfunction

  task automatic check_idle(input string tag);
    check(busy_o == 1'b0, {tag, " busy"}, busy_o, 0);
    check(cyc_idx_o == '0, {tag, " idx"}, cyc_idx_o, 0);
    check(stall_o == 1'b0, {tag, " stall"}, stall_o, 0);
    check(done_o == 1'b0, {tag, " done"}, done_o, 0);
  endtask

  // pat 0: wait high for wall cycles 1..S+H-1
  // pat 1: wait high everywhere except wall cycle S (R8)
  // pat 2: like pat 0 with start held high and a different dur (R1)
  task automatic run_access(input int d, input bit en, input int h, input int pat);
    int s, n, total, eff_d;
    bit on;
    eff_d = (d == 0) ? 1 : d;
    s  = mid_of(eff_d);
    on = en && (eff_d >= 4);
    n  = (on && pat != 1) ? h : 0;
    total = eff_d + n;
    @(negedge clk);
    start_i   = 1'b1;
    dur_i     = DUR_W'(d);
    wait_en_i = en;
    wait_i    = (pat == 1) ? 1'b1 : 1'b0;
    @(posedge clk);
    for (int c = 1; c <= total; c++) begin
      int e_idx;
      bit e_stall, w;
      logic [N_EDGE-1:0] ev;
      @(negedge clk);
      if (pat == 2) begin
        start_i = 1'b1;
        dur_i   = DUR_W'(d + 3);
        wait_en_i = ~en;
      end else begin
        start_i = 1'b0;
      end
      if (pat == 1) w = (c != s);
      else          w = (c <= s + h - 1);
      wait_i  = w;
      ev      = N_EDGE'(c) ^ N_EDGE'(2);
      edges_i = ev;
      e_stall = (c >= s + 1) && (c <= s + n);
      if (c <= s)          e_idx = c;
      else if (c <= s + n) e_idx = s + 1;
      else                 e_idx = c - n;
      #1;
      check(busy_o == 1'b1, "R1 busy during access", busy_o, 1);
      check(cyc_idx_o == DUR_W'(e_idx), (n > 0) ? "R4 R5 index" : "R2 R7 index",
            cyc_idx_o, e_idx);
      check(stall_o == e_stall, (pat == 1) ? "R8 stall" : "R3 R4 R5 R7 stall",
            stall_o, e_stall);
      check(edges_o == (e_stall ? '0 : ev), "R6 edges_o", edges_o,
            e_stall ? 0 : int'(ev));
      check(done_o == (c == total), "R9 done", done_o, (c == total));
    end
    @(negedge clk);
    start_i = 1'b0;
    wait_i  = 1'b0;
    #1;
    check_idle("R9 idle after done");
  endtask

  initial begin
    #3;
    check_idle("R10 in reset");
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_idle("R10 after reset");
    // R1: zero length runs as one cycle
    run_access(0, 1'b1, 2, 0);
    for (int d = 1; d <= 10; d++)
      for (int en = 0; en < 2; en++)
        for (int h = 0; h < 4; h++)
          for (int pat = 0; pat < 3; pat++)
            run_access(d, en[0], h, pat);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule